// File: doc/BRIEF.md
# Differential Result Scaler and Formatter

This block is a digital model of a converter's transfer function. On a one-cycle sample strobe it takes two input voltages and a reference voltage, all in millivolts, and turns them into a 10-bit code. In differential mode the positive-minus-negative difference is amplified by a selectable gain of 1 or 20 before scaling. In single-ended mode only the positive input is used. The quotient is produced by a multi-cycle restoring divider. The result is clamped into the 10-bit range and held in a code register. The analog front end, sampling and noise are not modelled.

The held code is shown on a 16-bit result pair made of a high byte and a low byte. A live presentation flag chooses left-aligned or right-aligned placement. Because the placement is applied combinationally to the held code, toggling the flag changes the bytes in the same cycle, even while a new conversion is still running.

The sequencer has three states. `ST_IDLE` waits for a strobe. `ST_DIVIDE` runs one quotient bit per cycle for all numerator bits. `ST_COMMIT` writes the clamped code. The transitions are:
- IDLE→DIVIDE when the strobe is seen.
- DIVIDE→DIVIDE while bits remain.
- DIVIDE→COMMIT on the last bit.
- COMMIT→IDLE unconditionally.

Top module: `diff_result_formatter`

## Requirements
- R1: While reset is asserted and after it is released, the held code is 0 and both `res_hi` and `res_lo` read 0x00 until the first conversion commits.
- R2: With `single_ended`=1 the code is floor(vpos_mv × 1024 / vref_mv). `vneg_mv` and `gain_hi` have no effect.
- R3: With `single_ended`=0 the code is floor((vpos_mv − vneg_mv) × G × 1024 / vref_mv). G is 1 when `gain_hi`=0 and 20 when `gain_hi`=1. The division truncates toward zero. For example, 400 mV and 300 mV with G=20 and 2560 mV give 0x320.
- R4: In differential mode, if vpos_mv is below vneg_mv the code is 0x000.
- R5: A quotient of 1024 or more yields 0x3FF. This includes an input of exactly vref/G and any larger input. A `vref_mv` of 0 also yields 0x3FF.
- R6: With `fmt_left`=1 the code occupies bits 15:6 of {res_hi,res_lo} and bits 5:0 are zero. With `fmt_left`=0 the code occupies bits 9:0 and bits 15:10 are zero. For example, 0x320 reads hi 0xC8 / lo 0x00 left-aligned and hi 0x03 / lo 0x20 right-aligned.
- R7: A change of `fmt_left` alters the bytes in the same cycle and does not alter the held code, including while a conversion is in progress.
- R8: The inputs are sampled on the clock edge that sees `sample_stb`=1 in IDLE. The new code appears exactly 29 clock edges later. Until then the previous code is held.
- R9: A strobe that arrives while a conversion is in progress (DIVIDE or COMMIT) is ignored. Its inputs never reach the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sample_stb | input | 1 | One-cycle request to convert the present inputs |
| single_ended | input | 1 | 1 = use positive input alone, 0 = differential |
| gain_hi | input | 1 | Differential gain: 0 = 1x, 1 = 20x |
| fmt_left | input | 1 | 1 = left-aligned result, 0 = right-aligned |
| vpos_mv | input | 13 | Positive input in millivolts |
| vneg_mv | input | 13 | Negative input in millivolts |
| vref_mv | input | 13 | Reference in millivolts |
| res_lo | output | 8 | Low byte of the formatted result |
| res_hi | output | 8 | High byte of the formatted result |

## Verification
The hardest case to reach from the ports is a flag change or a second strobe landing in the middle of the 28-cycle division. At that point the held code must stay old while the presented bytes move, and the fresh inputs must be dropped. The stimulus fires a strobe, then toggles `fmt_left` and re-strobes with different inputs several cycles into the division. A per-cycle behavioural model with a latency counter predicts the bytes on every clock. Exact-full-scale, one-LSB-below, negative-difference and zero-reference vectors cover the clamp edges.

// File: rtl/drf_pkg.sv
package drf_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_DIVIDE = 2'd1,
        ST_COMMIT = 2'd2
    } drf_state_e;
endpackage

// File: rtl/drf_numerator.sv
// Builds the dividend: clamped difference (or single input) times gain, times 2^CODE_W.
module drf_numerator #(
    parameter int MV_W    = 13,
    parameter int CODE_W  = 10,
    parameter int GAIN_HI = 20,
    parameter int GAIN_W  = 5,
    parameter int NUM_W   = 28
) (
    input  logic              single_ended,
    input  logic              gain_hi,
    input  logic [MV_W-1:0]   vpos_mv,
    input  logic [MV_W-1:0]   vneg_mv,
    output logic [NUM_W-1:0]  num_o
);
    localparam int PROD_W = MV_W + GAIN_W;

    logic [MV_W:0]       diff_ext;
    logic [MV_W-1:0]     magnitude;
    logic [GAIN_W-1:0]   factor;
    logic [PROD_W-1:0]   product;

    always_comb begin
        diff_ext = {1'b0, vpos_mv} - {1'b0, vneg_mv};
        if (single_ended) begin
            magnitude = vpos_mv;
            factor    = GAIN_W'(1);
        end else begin
            // borrow out means negative difference: saturate to zero
            magnitude = diff_ext[MV_W] ? '0 : diff_ext[MV_W-1:0];
            factor    = gain_hi ? GAIN_W'(GAIN_HI) : GAIN_W'(1);
        end
        product = PROD_W'(magnitude) * PROD_W'(factor);
        num_o   = {product, {CODE_W{1'b0}}};
    end

    // R4: negative differential input must give an empty dividend
    always_comb begin
        if (!single_ended && (vpos_mv < vneg_mv)) begin
            assert_neg_zero_R4: assert (num_o == '0);
        end
    end
endmodule

// File: rtl/drf_divider.sv
// Restoring divider sequenced by a three-state machine; one quotient bit per cycle.
module drf_divider
    import drf_pkg::*;
#(
    parameter int MV_W  = 13,
    parameter int NUM_W = 28,
    parameter int CNT_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [NUM_W-1:0]  num_i,
    input  logic [MV_W-1:0]   den_i,
    output logic [NUM_W-1:0]  quot_o,
    output logic              done_o
);
    drf_state_e         state_q, state_nx;
    logic [CNT_W-1:0]   cnt_q;
    logic [MV_W-1:0]    den_q;
    logic [MV_W-1:0]    rem_q;
    logic [NUM_W-1:0]   quo_q;
    logic [MV_W:0]      rem_sh;
    logic               take;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_nx;
    end

    // next-state logic
    always_comb begin
        state_nx = state_q;
        unique case (state_q)
            ST_IDLE:   if (start_i)        state_nx = ST_DIVIDE;
            ST_DIVIDE: if (cnt_q == '0)    state_nx = ST_COMMIT;
            ST_COMMIT:                     state_nx = ST_IDLE;
            default:                       state_nx = ST_IDLE;
        endcase
    end

    // output process
    always_comb begin
        done_o = (state_q == ST_COMMIT);
        quot_o = quo_q;
    end

    // datapath
    always_comb begin
        rem_sh = {rem_q, quo_q[NUM_W-1]};
        take   = (rem_sh >= {1'b0, den_q});
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            den_q <= '0;
            rem_q <= '0;
            quo_q <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (start_i) begin
                        cnt_q <= CNT_W'(NUM_W - 1);
                        den_q <= den_i;
                        rem_q <= '0;
                        quo_q <= num_i;
                    end
                end
                ST_DIVIDE: begin
                    cnt_q <= cnt_q - CNT_W'(1);
                    if (take) begin
                        rem_q <= MV_W'(rem_sh - {1'b0, den_q});
                        quo_q <= {quo_q[NUM_W-2:0], 1'b1};
                    end else begin
                        rem_q <= rem_sh[MV_W-1:0];
                        quo_q <= {quo_q[NUM_W-2:0], 1'b0};
                    end
                end
                default: ;
            endcase
        end
    end

    assert_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DIVIDE && cnt_q != '0) |=>
        (state_q == ST_DIVIDE && cnt_q == $past(cnt_q) - CNT_W'(1)));

    assert_last_bit_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DIVIDE && cnt_q == '0) |=> (state_q == ST_COMMIT));

    assert_commit_once_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_COMMIT) |=> (state_q == ST_IDLE));

    assert_busy_ignore_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_IDLE && start_i) |=> $stable(den_q));
endmodule

// File: rtl/drf_presenter.sv
// Holds the clamped code and places it in the 16-bit result pair.
module drf_presenter #(
    parameter int CODE_W = 10,
    parameter int WORD_W = 16,
    parameter int NUM_W  = 28
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                done_i,
    input  logic [NUM_W-1:0]    quot_i,
    input  logic                fmt_left,
    output logic [WORD_W/2-1:0] res_lo,
    output logic [WORD_W/2-1:0] res_hi
);
    localparam int PAD_W  = WORD_W - CODE_W;
    localparam int BYTE_W = WORD_W / 2;

    logic [CODE_W-1:0] code_q;
    logic [CODE_W-1:0] code_nx;
    logic              ovf;
    logic [WORD_W-1:0] word;

    always_comb begin
        ovf     = |quot_i[NUM_W-1:CODE_W];
        code_nx = ovf ? '1 : quot_i[CODE_W-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      code_q <= '0;
        else if (done_i) code_q <= code_nx;
    end

    always_comb begin
        if (fmt_left) word = {code_q, {PAD_W{1'b0}}};
        else          word = {{PAD_W{1'b0}}, code_q};
        res_hi = word[WORD_W-1:BYTE_W];
        res_lo = word[BYTE_W-1:0];
    end

    assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !done_i |=> $stable(code_q));

    assert_clamp_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (done_i && ovf) |=> (&code_q));

    assert_fmt_no_touch_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!done_i && fmt_left != $past(fmt_left)) |-> $stable(code_q));
endmodule

// File: rtl/diff_result_formatter.sv
module diff_result_formatter #(
    parameter int MV_W    = 13,
    parameter int CODE_W  = 10,
    parameter int WORD_W  = 16,
    parameter int GAIN_HI = 20
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                sample_stb,
    input  logic                single_ended,
    input  logic                gain_hi,
    input  logic                fmt_left,
    input  logic [MV_W-1:0]     vpos_mv,
    input  logic [MV_W-1:0]     vneg_mv,
    input  logic [MV_W-1:0]     vref_mv,
    output logic [WORD_W/2-1:0] res_lo,
    output logic [WORD_W/2-1:0] res_hi
);
    localparam int GAIN_W = $clog2(GAIN_HI + 1);
    localparam int NUM_W  = MV_W + GAIN_W + CODE_W;
    localparam int CNT_W  = $clog2(NUM_W);

    logic [NUM_W-1:0] num;
    logic [NUM_W-1:0] quot;
    logic             done;

    drf_numerator #(
        .MV_W(MV_W), .CODE_W(CODE_W), .GAIN_HI(GAIN_HI),
        .GAIN_W(GAIN_W), .NUM_W(NUM_W)
    ) u_num (
        .single_ended(single_ended),
        .gain_hi     (gain_hi),
        .vpos_mv     (vpos_mv),
        .vneg_mv     (vneg_mv),
        .num_o       (num)
    );

    drf_divider #(
        .MV_W(MV_W), .NUM_W(NUM_W), .CNT_W(CNT_W)
    ) u_div (
        .clk    (clk),
        .rst_n  (rst_n),
        .start_i(sample_stb),
        .num_i  (num),
        .den_i  (vref_mv),
        .quot_o (quot),
        .done_o (done)
    );

    drf_presenter #(
        .CODE_W(CODE_W), .WORD_W(WORD_W), .NUM_W(NUM_W)
    ) u_pres (
        .clk     (clk),
        .rst_n   (rst_n),
        .done_i  (done),
        .quot_i  (quot),
        .fmt_left(fmt_left),
        .res_lo  (res_lo),
        .res_hi  (res_hi)
    );
endmodule

// File: tb/diff_result_formatter_bench.sv
module diff_result_formatter_bench;
    localparam int LAT = 29;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sample_stb = 1'b0;
    logic        single_ended = 1'b0;
    logic        gain_hi = 1'b0;
    logic        fmt_left = 1'b0;
    logic [12:0] vpos_mv = '0;
    logic [12:0] vneg_mv = '0;
    logic [12:0] vref_mv = '0;
    logic [7:0]  res_lo, res_hi;

    int vectors = 0;
    int fails = 0;
    bit check_en = 1'b0;
    string cur_tag = "R8";

    // behavioural model state
    int exp_code = 0;
    int pend_code = 0;
    int busy_cnt = 0;

    always #10 clk = ~clk;

    diff_result_formatter u_diff_result_formatter (
        .clk(clk), .rst_n(rst_n), .sample_stb(sample_stb),
        .single_ended(single_ended), .gain_hi(gain_hi), .fmt_left(fmt_left),
        .vpos_mv(vpos_mv), .vneg_mv(vneg_mv), .vref_mv(vref_mv),
        .res_lo(res_lo), .res_hi(res_hi)
    );

    function automatic int calc(int vp, int vn, int vr, bit g, bit se);
        int n, d, q;
        if (se) n = vp * 1024;
        else begin
            d = vp - vn;
            if (d < 0) d = 0;
            n = d * (g ? 20 : 1) * 1024;
        end
        if (vr == 0) return 1023;
        q = n / vr;
        if (q > 1023) q = 1023;
        return q;
    endfunction

    function automatic int fmt(int code, bit left);
        return left ? (code * 64) : code;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            exp_code = 0; busy_cnt = 0;
        end else if (busy_cnt > 0) begin
            busy_cnt = busy_cnt - 1;
            if (busy_cnt == 0) exp_code = pend_code;
        end else if (sample_stb) begin
            pend_code = calc(int'(vpos_mv), int'(vneg_mv), int'(vref_mv), gain_hi, single_ended);
            busy_cnt = LAT;
        end
    end

    always @(posedge clk) begin
        #3;
        if (check_en) begin
            int got, want;
            got  = {res_hi, res_lo};
            want = fmt(exp_code, fmt_left);
            vectors++;
            if (got !== want) begin
                fails++;
                $display("FAIL %s cycle compare: got %04h expected %04h", cur_tag, got, want);
            end
        end
    end

    task automatic chk(string tag, int got, int want);
        vectors++;
        if (got !== want) begin
            fails++;
            $display("FAIL %s: got %04h expected %04h", tag, got, want);
        end
    endtask

    task automatic launch(int vp, int vn, int vr, bit g, bit se);
        @(negedge clk);
        vpos_mv = 13'(vp); vneg_mv = 13'(vn); vref_mv = 13'(vr);
        gain_hi = g; single_ended = se; sample_stb = 1'b1;
        @(negedge clk);
        sample_stb = 1'b0;
    endtask

    task automatic convert(string tag, int vp, int vn, int vr, bit g, bit se);
        cur_tag = tag;
        launch(vp, vn, vr, g, se);
        repeat (LAT + 1) @(negedge clk);
        chk(tag, {res_hi, res_lo}, fmt(calc(vp, vn, vr, g, se), fmt_left));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: got hang expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        int seed;
        seed = 12345;
        repeat (3) @(negedge clk);
        chk("R1 in reset", {res_hi, res_lo}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 after reset", {res_hi, res_lo}, 0);
        check_en = 1'b1;

        // R3 worked example, then R6 placements
        fmt_left = 1'b1;
        convert("R3", 400, 300, 2560, 1'b1, 1'b0);
        chk("R6 left hi", int'(res_hi), 'hC8);
        chk("R6 left lo", int'(res_lo), 'h00);
        fmt_left = 1'b0;
        #1;
        chk("R7 right hi", int'(res_hi), 'h03);
        chk("R6 right lo", int'(res_lo), 'h20);

        convert("R3", 1500, 500, 2000, 1'b0, 1'b0);
        convert("R3", 7, 0, 3000, 1'b0, 1'b0);
        convert("R2", 1000, 4000, 2560, 1'b1, 1'b1);
        convert("R2", 1000, 0, 2560, 1'b0, 1'b1);
        convert("R4", 300, 400, 2560, 1'b1, 1'b0);
        chk("R4 zero", {res_hi, res_lo}, 0);
        convert("R5", 256, 128, 2560, 1'b1, 1'b0);
        chk("R5 exact full scale", {res_hi, res_lo}, 'h3FF);
        convert("R5", 1023, 0, 1024, 1'b0, 1'b0);
        chk("R5 one lsb below", {res_hi, res_lo}, 'h3FF);
        convert("R5", 1022, 0, 1024, 1'b0, 1'b0);
        chk("R5 two lsb below", {res_hi, res_lo}, 'h3FE);
        convert("R5", 8000, 0, 1000, 1'b0, 1'b1);
        convert("R5", 100, 0, 0, 1'b0, 1'b0);

        // R7: toggle placement mid-conversion; old code must still show
        cur_tag = "R7";
        fmt_left = 1'b0;
        launch(50, 10, 2000, 1'b1, 1'b0);
        repeat (5) @(negedge clk);
        fmt_left = 1'b1;
        #1 chk("R7 mid-conversion left", {res_hi, res_lo}, fmt(1023, 1'b1));
        repeat (4) @(negedge clk);
        fmt_left = 1'b0;
        #1 chk("R7 mid-conversion right", {res_hi, res_lo}, 1023);
        repeat (LAT - 9) @(negedge clk);
        chk("R8 committed", {res_hi, res_lo}, calc(50, 10, 2000, 1'b1, 1'b0));

        // R9: second strobe during division is dropped
        cur_tag = "R9";
        launch(200, 0, 2560, 1'b0, 1'b0);
        repeat (6) @(negedge clk);
        launch(2000, 0, 2560, 1'b0, 1'b0);
        repeat (LAT) @(negedge clk);
        chk("R9 first wins", {res_hi, res_lo}, calc(200, 0, 2560, 1'b0, 1'b0));

        // mixed vectors
        for (int i = 0; i < 20; i++) begin
            int a, b, r;
            seed = seed * 1103515245 + 12345;
            a = (seed >>> 8) & 16'h1FFF;
            seed = seed * 1103515245 + 12345;
            b = (seed >>> 8) & 16'h1FFF;
            seed = seed * 1103515245 + 12345;
            r = ((seed >>> 8) & 16'h1FFF) | 1;
            fmt_left = i[0];
            convert("R3", a % 3000, b % 3000, r, i[1], i[2] & i[3]);
        end

        check_en = 1'b0;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule